// File: doc/BRIEF.md
# Restartable Program Counter with Segment Address Translation

This unit owns the program counter of a pipelined processor. On every clock it picks the next PC from one of six sources: the output of its own incrementer, the current value (a hold for stalls), zero for interrupt entry, a stored branch target, or either of two 32-bit data buses. Each time the PC really changes, the value it replaces is pushed into a restart history. The history keeps the three most recent earlier PCs, so that an exception handler can save them and resume the pipeline later. A separate register keeps one future PC, the pending branch target, which the branch source uses.

The current PC is also turned into an external word address. When translation is enabled, a mask register marks the high-order bits that belong to the segment, and a process-ID register supplies the values placed into those bits. If any PC bit inside the masked region is nonzero, the access lies outside the legal segment. In that case the address output keeps its previous value and a fault flag is raised. The mask and process-ID registers can be written only in supervisor state. A write attempted outside supervisor state is dropped and reported.

Top module: `pc_restart_unit`

## Requirements
- R1: After reset, pc_out, every history entry, ext_addr, seg_fault and priv_err are all zero, and the mask, process-ID and pending-target registers are zero.
- R2: At each clock edge pc_out takes the value chosen by pc_src: 0 gives pc_out+1, 2 gives zero, 3 gives the pending target, 4 gives bus_a and 5 gives bus_b.
- R3: pc_src values 1, 6 and 7 leave pc_out and every history entry unchanged.
- R4: On every edge where pc_src is 0, 2, 3, 4 or 5, the history shifts. Entry 0 (hist_flat[31:0]) takes the old pc_out, entry 1 (bits [63:32]) takes the old entry 0, and entry 2 (bits [95:64]) takes the old entry 1.
- R5: When tgt_wr is high, the pending target loads tgt_in at the edge. A branch selected at that same edge uses the target value stored before the edge.
- R6: ext_addr is registered. After an edge where no violation occurs, it equals the low 24 bits of the PC from before that edge. When map_en is high, the masked bits of that PC are first replaced by the matching process-ID bits: (pc & ~mask) | (pid & mask).
- R7: A violation is map_en high together with (pc_out & mask) nonzero. After an edge where a violation occurs, seg_fault is 1 and ext_addr keeps its previous value. After an edge with no violation, seg_fault is 0.
- R8: A write with cfg_wr=1 and supv=1 loads cfg_data into the mask register when cfg_sel=0, and into the process-ID register when cfg_sel=1. The new value governs translation from the following edge on.
- R9: A write with cfg_wr=1 and supv=0 changes neither register. priv_err is 1 for the cycle after each such write and 0 after every other edge.
- R10: The incrementer wraps, so pc_src=0 with pc_out=32'hFFFF_FFFF yields zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| pc_src | input | 3 | Next-PC source code |
| bus_a | input | 32 | First data bus value |
| bus_b | input | 32 | Second data bus value |
| tgt_wr | input | 1 | Load the pending branch target |
| tgt_in | input | 32 | New pending branch target |
| map_en | input | 1 | Enable segment translation and checking |
| supv | input | 1 | Supervisor state |
| cfg_wr | input | 1 | Write request for a translation register |
| cfg_sel | input | 1 | 0 selects the mask register, 1 the process-ID register |
| cfg_data | input | 32 | Write data for the translation register |
| pc_out | output | 32 | Current PC |
| hist_flat | output | 96 | Restart history, newest entry in the low word |
| ext_addr | output | 24 | External word address |
| seg_fault | output | 1 | Out-of-segment access seen at the previous edge |
| priv_err | output | 1 | Non-supervisor write seen at the previous edge |

## Verification
A wrong PC shows on pc_out at the edge where it is taken. One edge later it also shows in history entry 0 and on ext_addr, and it then moves down the history one entry per update. A corrupted mask or process-ID register stays hidden while map_en is low. It shows on ext_addr or seg_fault at the first edge where translation is enabled and the PC touches the affected bits. For that reason the bench switches translation on and off with random masks and PCs near the masked boundary. It compares every output against a behavioural model on every cycle.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    SRC_INC    = 3'd0,
    SRC_HOLD   = 3'd1,
    SRC_ZERO   = 3'd2,
    SRC_BRANCH = 3'd3,
    SRC_BUS_A  = 3'd4,
    SRC_BUS_B  = 3'd5
  } pc_src_e;

  localparam int unsigned SRC_W = 3;
endpackage

// File: rtl/pcu_next_sel.sv
module pcu_next_sel
  import pcu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [SRC_W-1:0] sel,
  input  logic [W-1:0]     pc,
  input  logic [W-1:0]     tgt,
  input  logic [W-1:0]     bus_a,
  input  logic [W-1:0]     bus_b,
  output logic [W-1:0]     nxt,
  output logic             upd
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] inc_val;

  // dedicated incrementer, wraps naturally
  assign inc_val = pc + ONE;

  always_comb begin
    nxt = pc;
    upd = 1'b1;
    case (sel)
      SRC_INC:    nxt = inc_val;
      SRC_ZERO:   nxt = '0;
      SRC_BRANCH: nxt = tgt;
      SRC_BUS_A:  nxt = bus_a;
      SRC_BUS_B:  nxt = bus_b;
      default: begin
        nxt = pc;
        upd = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pcu_history.sv
module pcu_history #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift,
  input  logic [W-1:0]       pc_in,
  output logic [DEPTH*W-1:0] hist_flat
);
  logic [W-1:0] ent_q [DEPTH];
  logic [W-1:0] ent_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_comb ent_d[i] = shift ? pc_in : ent_q[i];
    end else begin : g_tail
      always_comb ent_d[i] = shift ? ent_q[i-1] : ent_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[i] <= '0;
      else        ent_q[i] <= ent_d[i];
    end

    assign hist_flat[(i+1)*W-1 -: W] = ent_q[i];
  end
endmodule

// File: rtl/pcu_cfg.sv
module pcu_cfg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         sel,
  input  logic [W-1:0] data,
  input  logic         supv,
  output logic [W-1:0] mask,
  output logic [W-1:0] pid,
  output logic         priv_err
);
  logic [W-1:0] mask_q, mask_d;
  logic [W-1:0] pid_q, pid_d;
  logic         perr_q, perr_d;
  logic         wr_ok;

  assign wr_ok = wr && supv;

  always_comb begin
    mask_d = mask_q;
    pid_d  = pid_q;
    if (wr_ok && !sel) mask_d = data;
    if (wr_ok && sel)  pid_d  = data;
    perr_d = wr && !supv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pid_q  <= '0;
      perr_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      pid_q  <= pid_d;
      perr_q <= perr_d;
    end
  end

  assign mask     = mask_q;
  assign pid      = pid_q;
  assign priv_err = perr_q;
endmodule

// File: rtl/pcu_xlate.sv
module pcu_xlate #(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [W-1:0]      pc,
  input  logic [W-1:0]      mask,
  input  logic [W-1:0]      pid,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              fault
);
  logic [W-1:0]      virt;
  logic              viol;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              fault_q, fault_d;

  always_comb begin
    virt    = en ? ((pc & ~mask) | (pid & mask)) : pc;
    viol    = en && (|(pc & mask));
    addr_d  = viol ? addr_q : virt[ADDR_W-1:0];
    fault_d = viol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      fault_q <= fault_d;
    end
  end

  assign ext_addr = addr_q;
  assign fault    = fault_q;
endmodule

// File: rtl/pc_restart_unit.sv
module pc_restart_unit
  import pcu_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DEPTH  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         pc_src,
  input  logic [W-1:0]       bus_a,
  input  logic [W-1:0]       bus_b,
  input  logic               tgt_wr,
  input  logic [W-1:0]       tgt_in,
  input  logic               map_en,
  input  logic               supv,
  input  logic               cfg_wr,
  input  logic               cfg_sel,
  input  logic [W-1:0]       cfg_data,
  output logic [W-1:0]       pc_out,
  output logic [DEPTH*W-1:0] hist_flat,
  output logic [ADDR_W-1:0]  ext_addr,
  output logic               seg_fault,
  output logic               priv_err
);
  logic sync1_q, sync2_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end
  assign rst_sync_n = sync2_q;

  logic [W-1:0] pc_q, pc_d;
  logic [W-1:0] tgt_q, tgt_d;
  logic         upd;
  logic [W-1:0] mask, pid;

  pcu_next_sel #(.W(W)) u_sel (
    .sel   (pc_src),
    .pc    (pc_q),
    .tgt   (tgt_q),
    .bus_a (bus_a),
    .bus_b (bus_b),
    .nxt   (pc_d),
    .upd   (upd)
  );

  always_comb tgt_d = tgt_wr ? tgt_in : tgt_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q  <= '0;
      tgt_q <= '0;
    end else begin
      if (upd) pc_q <= pc_d;
      tgt_q <= tgt_d;
    end
  end

  pcu_history #(.W(W), .DEPTH(DEPTH)) u_hist (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .shift     (upd),
    .pc_in     (pc_q),
    .hist_flat (hist_flat)
  );

  pcu_cfg #(.W(W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr       (cfg_wr),
    .sel      (cfg_sel),
    .data     (cfg_data),
    .supv     (supv),
    .mask     (mask),
    .pid      (pid),
    .priv_err (priv_err)
  );

  pcu_xlate #(.W(W), .ADDR_W(ADDR_W)) u_xl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (map_en),
    .pc       (pc_q),
    .mask     (mask),
    .pid      (pid),
    .ext_addr (ext_addr),
    .fault    (seg_fault)
  );

  assign pc_out = pc_q;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DEPTH  = 3
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [2:0]         pc_src,
  input logic               cfg_wr,
  input logic               supv,
  input logic [W-1:0]       pc_out,
  input logic [DEPTH*W-1:0] hist_flat,
  input logic [ADDR_W-1:0]  ext_addr,
  input logic               seg_fault,
  input logic               priv_err
);
  logic is_hold;
  assign is_hold = (pc_src == 3'd1) || (pc_src == 3'd6) || (pc_src == 3'd7);

  // R3
  hold_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_hold |=> ($stable(pc_out) && $stable(hist_flat)));

  // R4
  hist_push_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !is_hold |=> (hist_flat[W-1:0] == $past(pc_out)));

  // R2
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_src == 3'd2) |=> (pc_out == '0));

  // R7
  fault_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seg_fault |-> $stable(ext_addr));

  // R9
  priv_err_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_wr && !supv) |=> priv_err);

  // R9
  priv_err_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cfg_wr && !supv) |=> !priv_err);
endmodule

bind pc_restart_unit pcu_checker #(.W(W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .pc_src     (pc_src),
  .cfg_wr     (cfg_wr),
  .supv       (supv),
  .pc_out     (pc_out),
  .hist_flat  (hist_flat),
  .ext_addr   (ext_addr),
  .seg_fault  (seg_fault),
  .priv_err   (priv_err)
);

// File: tb/pc_restart_unit_bench.sv
`timescale 1ns/1ps
module pc_restart_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  pc_src = 3'd1;
  logic [31:0] bus_a = '0, bus_b = '0, tgt_in = '0, cfg_data = '0;
  logic        tgt_wr = 1'b0, map_en = 1'b0, supv = 1'b0, cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [31:0] pc_out;
  logic [95:0] hist_flat;
  logic [23:0] ext_addr;
  logic        seg_fault, priv_err;

  always #2.5 clk = ~clk;

  pc_restart_unit u_pc_restart_unit (
    .clk(clk), .rst_n(rst_n), .pc_src(pc_src), .bus_a(bus_a), .bus_b(bus_b),
    .tgt_wr(tgt_wr), .tgt_in(tgt_in), .map_en(map_en), .supv(supv),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .pc_out(pc_out), .hist_flat(hist_flat), .ext_addr(ext_addr),
    .seg_fault(seg_fault), .priv_err(priv_err)
  );

  // behavioural reference
  logic [31:0] m_pc, m_tgt, m_mask, m_pid;
  logic [31:0] m_hist [$];
  logic [23:0] m_addr;
  logic        m_fault, m_perr, m_s1, m_s2;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;
  string       phase = "R1";

  initial begin
    m_hist = '{32'd0, 32'd0, 32'd0};
  end

  always @(posedge clk) begin
    if (!rst_n || !m_s2) begin
      m_pc = 0; m_tgt = 0; m_mask = 0; m_pid = 0; m_addr = 0;
      m_fault = 0; m_perr = 0;
      m_hist = '{32'd0, 32'd0, 32'd0};
    end else begin
      logic [31:0] old_pc, virt;
      logic        viol;
      old_pc = m_pc;
      viol = map_en && ((m_pc & m_mask) != 0);
      virt = map_en ? ((m_pc & ~m_mask) | (m_pid & m_mask)) : m_pc;
      if (!viol) m_addr = virt[23:0];
      m_fault = viol;
      case (pc_src)
        3'd0: m_pc = m_pc + 1;
        3'd2: m_pc = 0;
        3'd3: m_pc = m_tgt;
        3'd4: m_pc = bus_a;
        3'd5: m_pc = bus_b;
        default: ;
      endcase
      if (pc_src inside {3'd0, 3'd2, 3'd3, 3'd4, 3'd5}) begin
        m_hist.push_front(old_pc);
        void'(m_hist.pop_back());
      end
      if (tgt_wr) m_tgt = tgt_in;
      m_perr = cfg_wr && !supv;
      if (cfg_wr && supv) begin
        if (cfg_sel) m_pid = tgt_zero(cfg_data);
        else         m_mask = cfg_data;
      end
    end
    if (!rst_n) begin m_s1 = 0; m_s2 = 0; end
    else begin m_s2 = m_s1; m_s1 = 1; end
  end

  function automatic logic [31:0] tgt_zero(input logic [31:0] v);
    return v;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("pc_out", pc_out, m_pc);
    for (int i = 0; i < 3; i++)
      chk($sformatf("R4 hist%0d", i), hist_flat[i*32 +: 32], m_hist[i]);
    chk("R6 ext_addr", {8'd0, ext_addr}, {8'd0, m_addr});
    chk("R7 seg_fault", {31'd0, seg_fault}, {31'd0, m_fault});
    chk("R9 priv_err", {31'd0, priv_err}, {31'd0, m_perr});
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic cfg_write(input logic s, input logic sel, input logic [31:0] d);
    supv = s; cfg_wr = 1; cfg_sel = sel; cfg_data = d;
    step();
    cfg_wr = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset values seen at the ports
    phase = "R1";
    chk("R1 pc_out in reset", pc_out, 32'd0);
    chk("R1 ext_addr in reset", {8'd0, ext_addr}, 32'd0);
    rst_n = 1;
    repeat (3) step();
    chk("R1 hist after reset", hist_flat[95:64] | hist_flat[63:32] | hist_flat[31:0], 32'd0);

    // R2: each source
    phase = "R2";
    pc_src = 3'd0; repeat (3) step();
    chk("R2 increment", pc_out, 32'd3);
    bus_a = 32'h100; pc_src = 3'd4; step();
    bus_b = 32'h2345; pc_src = 3'd5; step();
    chk("R2 bus_b", pc_out, 32'h2345);
    pc_src = 3'd2; step();
    chk("R2 zero", pc_out, 32'd0);

    // R5: target loaded while branching uses old target
    phase = "R5";
    pc_src = 3'd0; step();
    tgt_wr = 1; tgt_in = 32'h2000; pc_src = 3'd3; step();
    chk("R5 old target used", pc_out, 32'd0);
    tgt_wr = 0; step();
    chk("R5 new target used", pc_out, 32'h2000);

    // R3: hold and unused codes
    phase = "R3";
    pc_src = 3'd1; step();
    pc_src = 3'd6; step();
    pc_src = 3'd7; step();
    chk("R3 pc held", pc_out, 32'h2000);

    // R10: incrementer wraps
    phase = "R10";
    bus_a = 32'hFFFF_FFFF; pc_src = 3'd4; step();
    pc_src = 3'd0; step();
    chk("R10 wrap", pc_out, 32'd0);

    // R8: supervisor writes, translation
    phase = "R8";
    pc_src = 3'd1;
    cfg_write(1, 0, 32'hFFFF_0000);
    cfg_write(1, 1, 32'h00AB_0000);
    bus_a = 32'h0000_1234; pc_src = 3'd4; step();
    pc_src = 3'd1; map_en = 1; step();
    chk("R8 translated addr", {8'd0, ext_addr}, 32'h00AB_1234);

    // R7: violation holds address
    phase = "R7";
    bus_a = 32'h0005_0010; pc_src = 3'd4; step();
    pc_src = 3'd1; step();
    chk("R7 fault raised", {31'd0, seg_fault}, 32'd1);
    chk("R7 addr held", {8'd0, ext_addr}, 32'h00AB_1234);

    // R9: user-mode write ignored
    phase = "R9";
    bus_a = 32'h0000_0042; pc_src = 3'd4; step();
    pc_src = 3'd1;
    cfg_write(0, 0, 32'h0000_0000);
    chk("R9 priv_err", {31'd0, priv_err}, 32'd1);
    step();
    chk("R9 mask kept", {8'd0, ext_addr}, 32'h00AB_0042);

    // R6 and all: random traffic
    phase = "R6";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      pc_src = (r < 4) ? 3'd0 : 3'($urandom_range(1, 7));
      bus_a = ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 32'h3FFFF));
      bus_b = 32'($urandom_range(0, 32'hFFFFF));
      tgt_wr = ($urandom_range(0, 4) == 0);
      tgt_in = 32'($urandom_range(0, 32'h3FFFF));
      map_en = ($urandom_range(0, 2) != 0);
      supv = $urandom_range(0, 1);
      cfg_wr = ($urandom_range(0, 9) == 0);
      cfg_sel = $urandom_range(0, 1);
      cfg_data = cfg_sel ? $urandom : (32'hFFFF_FFFF << $urandom_range(14, 31));
      step();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired in phase %s actual=running expected=done", phase);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule